// File: doc/BRIEF.md
# Tagged Next-Block Prefetch Engine

This engine watches the lookups and line fills of a level-one data cache and decides when to ask the level-two cache for the next sequential block. Block addresses are counted in level-one line units, so the next block is always the current block address plus one, wrapping modulo 2^ADDR_W. One tag bit per cache line records whether the line came in through a prefetch. A fill stores that bit from the fill's origin. The first hit on a tagged line clears the bit and triggers a prefetch of the following block, so a run of sequential references keeps one block of lookahead in flight. A demand miss triggers a prefetch of the block that follows the missing one.

Requests are collected in a 16-entry circular queue, which the bus side drains through a valid/ready handshake. A request whose block address already waits in the queue is discarded. When the queue is full, an accepted request does not stall and is not lost. It replaces the oldest waiting entry, because a stale prefetch is the least likely to arrive before the demand reference it was meant to cover.

The access path is classified each cycle as ACC_NONE, ACC_MISS, ACC_HIT_PLAIN or ACC_HIT_TAGGED. Only ACC_MISS and ACC_HIT_TAGGED produce a request. The queue control is a three-state machine: Q_EMPTY, Q_PART and Q_FULL. Q_EMPTY goes to Q_PART on an accepted request. Q_PART goes to Q_EMPTY when the last entry is drained, and to Q_FULL when the sixteenth entry arrives. Q_FULL goes back to Q_PART when a drain comes without an accepted request. Q_FULL stays in Q_FULL on an overwrite, or when a drain and an accepted request fall in the same cycle.

Top module: `tagged_nbl_prefetcher`

## Requirements
- R1: After synchronous reset, pf_valid is 0 and every tag bit is 0, so a hit on any line issues no request.
- R2: A lookup with acc_valid=1 and acc_hit=0 (a demand miss on acc_blk) issues a request for acc_blk+1, wrapping modulo 2^ADDR_W. The request is visible at the queue output one clock after the lookup.
- R3: A fill with fill_is_pf=1 sets the line's tag to 1. The first hit on that line issues a request for acc_blk+1 and clears the tag, and a second hit issues nothing.
- R4: A fill with fill_is_pf=0 sets the line's tag to 0, and a hit on a line whose tag is 0 issues no request.
- R5: The queue presents the oldest surviving entry first, and pf_valid is 1 exactly when the queue holds an entry. An entry leaves when pf_valid and pf_ready are both 1 at a clock edge.
- R6: With 16 entries waiting and no drain, an accepted request overwrites the oldest entry. Both the head and the tail pointer advance, and the queue stays full.
- R7: A request whose block address equals an entry waiting in the queue at the start of the cycle is discarded.
- R8: When a fill and a hit target the same line in the same cycle, the hit is judged on the tag held before that cycle, and the stored tag takes the fill's value.
- R9: On a full queue, a drain and an accepted request in the same cycle remove only the drained head and append the new block at the tail.
- R10: While pf_valid is 1 and pf_ready is 0, pf_blk holds its value unless a full-queue overwrite occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | A cache lookup occurs this cycle |
| acc_hit | input | 1 | 1 = lookup hit, 0 = demand miss |
| acc_idx | input | IDX_W | Line index of the lookup |
| acc_blk | input | ADDR_W | Block address of the lookup, in line units |
| fill_valid | input | 1 | A line fill occurs this cycle |
| fill_idx | input | IDX_W | Line index being filled |
| fill_is_pf | input | 1 | 1 = prefetch fill, 0 = demand fill |
| pf_valid | output | 1 | The queue holds a request |
| pf_blk | output | ADDR_W | Block address of the oldest waiting request |
| pf_ready | input | 1 | The bus side takes the request this cycle |

## Verification
Two pairs of functions can meet in a single cycle. The first is a fill and a hit on the same line. The bench drives both in one cycle, once against a tagged line and once against an untagged line. It judges the result by whether a request emerges in that cycle, and by how a later hit on the line behaves. The second is a drain and an accepted request on a full queue. The bench fills the queue with sixteen requests, raises pf_ready in the same cycle as a new miss, and then drains the queue. It expects every original entry except the drained head, followed by the new block at the tail.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_MISS,
        ACC_HIT_PLAIN,
        ACC_HIT_TAGGED
    } acc_kind_e;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PART,
        Q_FULL
    } q_state_e;
endpackage

// File: rtl/pf_tag_array.sv
module pf_tag_array
    import pf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_hit,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [ADDR_W-1:0] acc_blk,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic              fill_is_pf,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_blk
);
    logic [NUM_LINES-1:0] tag_q;
    acc_kind_e            kind;

    // Classify the lookup on the tag held before this cycle.
    always_comb begin
        if (!acc_valid)             kind = ACC_NONE;
        else if (!acc_hit)          kind = ACC_MISS;
        else if (tag_q[acc_idx])    kind = ACC_HIT_TAGGED;
        else                        kind = ACC_HIT_PLAIN;
    end

    always_comb begin
        req_blk = acc_blk + ADDR_W'(1);
        unique case (kind)
            ACC_MISS, ACC_HIT_TAGGED: req_valid = 1'b1;
            ACC_NONE, ACC_HIT_PLAIN:  req_valid = 1'b0;
            default:                  req_valid = 1'b0;
        endcase
    end

    // Fill is written after the clear, so it wins on the same line.
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            if (kind == ACC_HIT_TAGGED) tag_q[acc_idx] <= 1'b0;
            if (fill_valid)             tag_q[fill_idx] <= fill_is_pf;
        end
    end
endmodule

// File: rtl/pf_req_queue.sv
module pf_req_queue
    import pf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16,            // power of two
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_blk,
    input  logic              pop_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_blk,
    output logic              full
);
    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  head, tail, head_nx, tail_nx;
    logic [CNT_W-1:0]  count, count_nx;
    q_state_e          state, state_nx;
    logic              dup, accept, pop, wr_en;

    // Duplicate search over occupied slots only.
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [PTR_W-1:0] off;
            off = PTR_W'(i) - head;
            if ((CNT_W'(off) < count) && (mem[i] == push_blk)) dup = 1'b1;
        end
    end

    assign accept = push && !dup;
    assign pop    = out_valid && pop_ready;

    always_comb begin
        head_nx  = head;
        tail_nx  = tail;
        count_nx = count;
        wr_en    = 1'b0;
        unique case (state)
            Q_EMPTY: begin
                if (accept) begin
                    wr_en    = 1'b1;
                    tail_nx  = tail + PTR_W'(1);
                    count_nx = CNT_W'(1);
                end
            end
            Q_PART: begin
                if (pop) head_nx = head + PTR_W'(1);
                if (accept) begin
                    wr_en   = 1'b1;
                    tail_nx = tail + PTR_W'(1);
                end
                count_nx = count + CNT_W'(accept) - CNT_W'(pop);
            end
            Q_FULL: begin
                if (accept) begin
                    // Drained or overwritten, the head slot is freed.
                    wr_en   = 1'b1;
                    tail_nx = tail + PTR_W'(1);
                    head_nx = head + PTR_W'(1);
                end else if (pop) begin
                    head_nx  = head + PTR_W'(1);
                    count_nx = count - CNT_W'(1);
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        if (count_nx == '0)                  state_nx = Q_EMPTY;
        else if (count_nx == CNT_W'(DEPTH))  state_nx = Q_FULL;
        else                                 state_nx = Q_PART;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= Q_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= head_nx;
            tail  <= tail_nx;
            count <= count_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[tail] <= push_blk;
    end

    assign out_valid = (state != Q_EMPTY);
    assign full      = (state == Q_FULL);
    assign out_blk   = mem[head];
endmodule

// File: rtl/tagged_nbl_prefetcher.sv
module tagged_nbl_prefetcher #(
    parameter int ADDR_W    = 32,
    parameter int NUM_LINES = 64,
    parameter int Q_DEPTH   = 16,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_hit,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [ADDR_W-1:0] acc_blk,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic              fill_is_pf,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_blk,
    input  logic              pf_ready
);
    logic              req_valid;
    logic [ADDR_W-1:0] req_blk;
    logic              q_full;

    pf_tag_array #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_tags (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_idx(acc_idx), .acc_blk(acc_blk),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_is_pf(fill_is_pf),
        .req_valid(req_valid), .req_blk(req_blk)
    );

    pf_req_queue #(.ADDR_W(ADDR_W), .DEPTH(Q_DEPTH)) u_queue (
        .clk(clk), .rst(rst),
        .push(req_valid), .push_blk(req_blk),
        .pop_ready(pf_ready),
        .out_valid(pf_valid), .out_blk(pf_blk),
        .full(q_full)
    );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_hit,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_blk,
    input logic              req_valid,
    input logic              q_full
);
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pf_valid);

    p_miss_requests_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_hit && !pf_ready) |=> pf_valid);

    p_full_stays_full_r6: assert property (@(posedge clk) disable iff (rst)
        (q_full && !pf_ready) |=> q_full);

    p_hold_when_stalled_r10: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready && !(q_full && req_valid)) |=> (pf_valid && $stable(pf_blk)));
endmodule

bind tagged_nbl_prefetcher pf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_blk(pf_blk),
    .req_valid(req_valid), .q_full(q_full)
);

// File: tb/tb_tagged_nbl_prefetcher.sv
module tb_tagged_nbl_prefetcher;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 6;

    logic              clk = 1'b0;
    logic              rst;
    logic              acc_valid, acc_hit, fill_valid, fill_is_pf, pf_ready;
    logic [IDX_W-1:0]  acc_idx, fill_idx;
    logic [ADDR_W-1:0] acc_blk;
    logic              pf_valid;
    logic [ADDR_W-1:0] pf_blk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tagged_nbl_prefetcher dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_idx(acc_idx), .acc_blk(acc_blk),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_is_pf(fill_is_pf),
        .pf_valid(pf_valid), .pf_blk(pf_blk), .pf_ready(pf_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_empty(input string req);
        chk(pf_valid == 1'b0, req, "queue not empty", 32'(pf_valid), 32'd0);
    endtask

    // Check head, take it, move to the next negedge.
    task automatic pop_expect(input logic [31:0] exp, input string req);
        chk(pf_valid == 1'b1 && pf_blk == exp, req, "head block", pf_blk, exp);
        pf_ready = 1'b1;
        @(negedge clk);
        pf_ready = 1'b0;
    endtask

    task automatic access(input bit hit, input int idx, input logic [31:0] blk);
        acc_valid = 1'b1; acc_hit = hit; acc_idx = IDX_W'(idx); acc_blk = blk;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic fill(input int idx, input bit is_pf);
        fill_valid = 1'b1; fill_idx = IDX_W'(idx); fill_is_pf = is_pf;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_reset;
        expect_empty("R1");
        for (int i = 0; i < 4; i++) access(1'b1, i * 9, 32'h40 + 32'(i));
        expect_empty("R1");
    endtask

    task automatic t_miss;
        access(1'b0, 1, 32'h100);
        pop_expect(32'h101, "R2");
        access(1'b0, 2, 32'hFFFF_FFFF);
        pop_expect(32'h0, "R2");
        expect_empty("R2");
    endtask

    task automatic t_tagged;
        fill(3, 1'b1);
        access(1'b1, 3, 32'h200);
        pop_expect(32'h201, "R3");
        access(1'b1, 3, 32'h200);
        expect_empty("R3");
    endtask

    task automatic t_demand_fill;
        fill(4, 1'b1);
        fill(4, 1'b0);
        access(1'b1, 4, 32'h250);
        expect_empty("R4");
    endtask

    task automatic t_order;
        access(1'b0, 0, 32'd10);
        access(1'b0, 0, 32'd20);
        access(1'b0, 0, 32'd30);
        repeat (3) begin
            chk(pf_valid && pf_blk == 32'd11, "R10", "held head", pf_blk, 32'd11);
            @(negedge clk);
        end
        pop_expect(32'd11, "R5");
        pop_expect(32'd21, "R5");
        pop_expect(32'd31, "R5");
        expect_empty("R5");
    endtask

    task automatic t_dup;
        access(1'b0, 0, 32'd50);
        access(1'b0, 0, 32'd50);
        pop_expect(32'd51, "R7");
        expect_empty("R7");
    endtask

    task automatic t_overflow;
        for (int k = 0; k < 17; k++) access(1'b0, 0, 32'd1000 + 32'(k));
        for (int k = 0; k < 16; k++) pop_expect(32'd1002 + 32'(k), "R6");
        expect_empty("R6");
    endtask

    task automatic t_full_pushpop;
        for (int k = 0; k < 16; k++) access(1'b0, 0, 32'd2000 + 32'(k));
        chk(pf_valid && pf_blk == 32'd2001, "R9", "head before", pf_blk, 32'd2001);
        acc_valid = 1'b1; acc_hit = 1'b0; acc_blk = 32'd2100; pf_ready = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; pf_ready = 1'b0;
        for (int k = 0; k < 15; k++) pop_expect(32'd2002 + 32'(k), "R9");
        pop_expect(32'd2101, "R9");
        expect_empty("R9");
    endtask

    task automatic t_collide;
        fill(7, 1'b1);
        fill_valid = 1'b1; fill_idx = 6'd7; fill_is_pf = 1'b0;
        acc_valid = 1'b1; acc_hit = 1'b1; acc_idx = 6'd7; acc_blk = 32'h300;
        @(negedge clk);
        fill_valid = 1'b0; acc_valid = 1'b0;
        pop_expect(32'h301, "R8");
        access(1'b1, 7, 32'h300);
        expect_empty("R8");
        fill(8, 1'b0);
        fill_valid = 1'b1; fill_idx = 6'd8; fill_is_pf = 1'b1;
        acc_valid = 1'b1; acc_hit = 1'b1; acc_idx = 6'd8; acc_blk = 32'h400;
        @(negedge clk);
        fill_valid = 1'b0; acc_valid = 1'b0;
        expect_empty("R8");
        access(1'b1, 8, 32'h400);
        pop_expect(32'h401, "R8");
    endtask

    initial begin
        rst = 1'b1; acc_valid = 1'b0; acc_hit = 1'b0; acc_idx = '0; acc_blk = '0;
        fill_valid = 1'b0; fill_idx = '0; fill_is_pf = 1'b0; pf_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_miss();
        t_tagged();
        t_demand_fill();
        t_order();
        t_dup();
        t_overflow();
        t_full_pushpop();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule